// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor as two registered, active-high requests: a normal interrupt request and a fast interrupt request. Every line has its own configuration word. The word chooses the output the line is routed to, whether the line is edge or level sensed, and a 5-bit priority. Software can mask single lines, block the whole bank, inspect the pending lines, read the number of the line that won, and acknowledge it.

Once an output is raised, the winning line number is frozen. It stays frozen until software writes an acknowledge to the control register, and only then does a new arbitration start. Lines are numbered 0 to 31. A system-wide interrupt number uses its upper bits to pick the bank and bits 4:0 to pick the line.

The parameter `FIQ_EN` set to 0 turns off the fast path, so that every source goes to the normal output. That lets the same block serve as a second-level controller whose normal output drives one line of a first-level bank. A cascaded interrupt must then be acknowledged in both banks.

Top module: `intc_bank`

Register map (byte addresses on `bus_addr`):
- Line configuration words sit at 0x00 + 4 × line.
- 0x80: mask.
- 0x84: status.
- 0x88: global block.
- 0x8C: control (write-only, reads 0).
- 0x90: normal source (read-only).
- 0x94: fast source (read-only).

## Requirements
- R1: After reset, the mask reads 0xFFFFFFFF, every line configuration word reads 0, status reads 0, the global block reads 1, and both outputs are low.
- R2: The mask register (0x80) reads back exactly the value last written. A line whose mask bit is 1 never raises an output, yet it still shows in status when it is pending.
- R3: The configuration word of line n is at address 4·n. Bit 0 routes the line to the fast output. Bit 1 selects sensing: 0 is edge and 1 is level. Bits 6:2 hold the priority. Reads return bits 6:0 as written, with the upper bits 0.
- R4: An edge-sensed line latches pending on a rising input. The latch stays set until that line is acknowledged as the current winner, or until it is cleared through status. A level-sensed line's pending bit follows its input. Status (0x84) reads the pending vector.
- R5: Among pending, unmasked lines routed to one output, the lowest priority value wins, and priority 0 is the most urgent. When priorities are equal, the lowest line number wins.
- R6: An output rises one clock after an arbitration finds a candidate. Its source register (normal at 0x90, fast at 0x94, line number in bits 4:0) then stays frozen. The output stays high until an acknowledge. It drops on the clock of the acknowledge write, and re-arbitration happens on the next clock.
- R7: Writing 1 to control bit 0 acknowledges the normal output, and writing 1 to bit 1 acknowledges the fast output. Writing 0x3 acknowledges both in the same cycle.
- R8: The global block register (0x88) resets to 1. While it is 1, no output rises. Writing 0 enables the bank.
- R9: With `FIQ_EN` = 0, configuration bit 0 is stored and read back but has no effect on routing. All lines go to the normal output, the fast output stays low, and the fast source register reads 0.
- R10: A status write ANDs the edge latches with the written data, so writing 0 clears every latch. A rising edge in the same cycle still sets its latch.
- R11: When a second-level bank's normal output drives line 31 of a first-level bank, an acknowledge written only to the first level brings the request back. Acknowledging at the second level and then at the first level clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Interrupt source lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
On every cycle, the embedded assertions check the following:
- A raised request holds and its source stays frozen until an acknowledge.
- An acknowledge drops the request on the next clock.
- A blocked bank never raises a request.
- A freshly raised request never names a line that was masked.

Only the bench's scenarios can show the following:
- The arbitration result itself: priority order and ties broken by line number.
- The edge latch behaviour and clearing it through status.
- Routing with the fast path enabled and disabled.
- The two-level cascade with acknowledges at both levels.

A behavioural model covers all of these and is compared on every clock.

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank #(
  parameter bit FIQ_EN = 1'b1,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   irq_in,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int NL = 32;
  localparam int LW = $clog2(NL);
  localparam int PW = 5;
  localparam int CW = PW + 2;
  localparam logic [AW-1:0] A_CFG_END = AW'(4 * NL);
  localparam logic [AW-1:0] A_MASK = AW'(128);
  localparam logic [AW-1:0] A_STAT = AW'(132);
  localparam logic [AW-1:0] A_GMSK = AW'(136);
  localparam logic [AW-1:0] A_CTRL = AW'(140);
  localparam logic [AW-1:0] A_ISRC = AW'(144);
  localparam logic [AW-1:0] A_FSRC = AW'(148);

  logic [CW-1:0]         cfg [NL];
  logic [NL-1:0]         mask, latch, prev, pend, to_fiq, clr_ack;
  logic [NL-1:0][PW-1:0] prio;
  logic                  gmask, irq_q, fiq_q;
  logic [LW-1:0]         isrc, fsrc;
  logic [LW:0]           win_i, win_f;

  wire [LW-1:0] wline = bus_addr[LW+1:2];
  wire wr_cfg  = bus_we && (bus_addr < A_CFG_END);
  wire wr_mask = bus_we && (bus_addr == A_MASK);
  wire wr_stat = bus_we && (bus_addr == A_STAT);
  wire wr_gmsk = bus_we && (bus_addr == A_GMSK);
  wire wr_ctrl = bus_we && (bus_addr == A_CTRL);
  wire ack_i   = wr_ctrl && bus_wdata[0];
  wire ack_f   = wr_ctrl && bus_wdata[1];
  wire [NL-1:0] rise = irq_in & ~prev;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      pend[i]   = cfg[i][1] ? irq_in[i] : latch[i];
      to_fiq[i] = FIQ_EN && cfg[i][0];
      prio[i]   = cfg[i][CW-1:2];
    end
  end

  function automatic logic [LW:0] pick(input logic [NL-1:0] c,
                                       input logic [NL-1:0][PW-1:0] p);
    logic          found;
    logic [LW-1:0] idx;
    logic [PW-1:0] bp;
    found = 1'b0;
    idx   = '0;
    bp    = '1;
    for (int i = 0; i < NL; i++)
      if (c[i] && (!found || p[i] < bp)) begin
        found = 1'b1;
        idx   = LW'(i);
        bp    = p[i];
      end
    return {found, idx};
  endfunction

  assign win_i = pick(pend & ~mask & ~to_fiq, prio);
  assign win_f = pick(pend & ~mask & to_fiq, prio);

  always_comb begin
    clr_ack = '0;
    if (irq_q && ack_i) clr_ack[isrc] = 1'b1;
    if (fiq_q && ack_f) clr_ack[fsrc] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) cfg[i] <= '0;
      mask  <= '1;
      latch <= '0;
      prev  <= '0;
      gmask <= 1'b1;
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      isrc  <= '0;
      fsrc  <= '0;
    end else begin
      prev <= irq_in;
      if (wr_cfg) cfg[wline] <= bus_wdata[CW-1:0];
      if (wr_mask) mask <= bus_wdata;
      if (wr_gmsk) gmask <= bus_wdata[0];
      latch <= ((wr_stat ? (latch & bus_wdata) : latch) & ~clr_ack) | rise;
      if (irq_q) begin
        if (ack_i) irq_q <= 1'b0;
      end else if (win_i[LW] && !gmask) begin
        irq_q <= 1'b1;
        isrc  <= win_i[LW-1:0];
      end
      if (fiq_q) begin
        if (ack_f) fiq_q <= 1'b0;
      end else if (win_f[LW] && !gmask) begin
        fiq_q <= 1'b1;
        fsrc  <= win_f[LW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_CFG_END) bus_rdata = {{(32-CW){1'b0}}, cfg[wline]};
    else case (bus_addr)
      A_MASK:  bus_rdata = mask;
      A_STAT:  bus_rdata = pend;
      A_GMSK:  bus_rdata = {31'd0, gmask};
      A_ISRC:  bus_rdata = {{(32-LW){1'b0}}, isrc};
      A_FSRC:  bus_rdata = {{(32-LW){1'b0}}, fsrc};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  p_hold_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(isrc));
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i |=> !irq_o);
  p_hold_fiq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && !ack_f |=> fiq_o && $stable(fsrc));
  p_fack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && ack_f |=> !fiq_o);
  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gmask && !irq_o && !fiq_o |=> !irq_o && !fiq_o);
  p_unmasked_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !(($past(mask) >> isrc) & 32'd1));
endmodule

// File: tb/tb_intc_bank.sv
`timescale 1ns/1ps
module tb_intc_bank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] in1 = '0, in2 = '0;
  logic        we1 = 1'b0, we2 = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata1, rdata2;
  wire         irq1, fiq1, irq2, fiq2;
  wire  [31:0] dut_in = {irq2, in1[30:0]};

  intc_bank #(.FIQ_EN(1'b1)) dut (.clk(clk), .rst_n(rst_n), .irq_in(dut_in),
    .bus_we(we1), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1),
    .irq_o(irq1), .fiq_o(fiq1));
  intc_bank #(.FIQ_EN(1'b0)) dut_l2 (.clk(clk), .rst_n(rst_n), .irq_in(in2),
    .bus_we(we2), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata2),
    .irq_o(irq2), .fiq_o(fiq2));

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [31:0] m_mask[2], m_latch[2], m_prev[2];
  logic [6:0]  m_cfg[2][32];
  logic        m_gm[2], m_irq[2], m_fiq[2];
  int          m_isrc[2], m_fsrc[2];
  logic        l2o;

  task automatic m_reset();
    for (int b = 0; b < 2; b++) begin
      m_mask[b] = '1; m_latch[b] = '0; m_prev[b] = '0; m_gm[b] = 1'b1;
      m_irq[b] = 1'b0; m_fiq[b] = 1'b0; m_isrc[b] = 0; m_fsrc[b] = 0;
      for (int i = 0; i < 32; i++) m_cfg[b][i] = '0;
    end
  endtask

  function automatic logic [31:0] m_pend(int b, logic [31:0] v);
    logic [31:0] p;
    for (int i = 0; i < 32; i++) p[i] = m_cfg[b][i][1] ? v[i] : m_latch[b][i];
    return p;
  endfunction

  task automatic m_step(int b, logic [31:0] v, logic we, bit fen);
    logic [31:0] p, nl;
    int bi, bp, bf, fp;
    bit fq, ai, af;
    p = m_pend(b, v);
    bi = -1; bp = 99; bf = -1; fp = 99;
    for (int i = 0; i < 32; i++) begin
      fq = fen && m_cfg[b][i][0];
      if (p[i] && !m_mask[b][i]) begin
        if (!fq && int'(m_cfg[b][i][6:2]) < bp) begin bi = i; bp = int'(m_cfg[b][i][6:2]); end
        if (fq && int'(m_cfg[b][i][6:2]) < fp) begin bf = i; fp = int'(m_cfg[b][i][6:2]); end
      end
    end
    ai = we && addr == 8'h8C && wdata[0];
    af = we && addr == 8'h8C && wdata[1];
    nl = (we && addr == 8'h84) ? (m_latch[b] & wdata) : m_latch[b];
    if (m_irq[b] && ai) nl[m_isrc[b]] = 1'b0;
    if (m_fiq[b] && af) nl[m_fsrc[b]] = 1'b0;
    nl = nl | (v & ~m_prev[b]);
    if (m_irq[b]) begin if (ai) m_irq[b] = 1'b0; end
    else if (bi >= 0 && !m_gm[b]) begin m_irq[b] = 1'b1; m_isrc[b] = bi; end
    if (m_fiq[b]) begin if (af) m_fiq[b] = 1'b0; end
    else if (bf >= 0 && !m_gm[b]) begin m_fiq[b] = 1'b1; m_fsrc[b] = bf; end
    m_latch[b] = nl;
    m_prev[b] = v;
    if (we && addr < 8'h80) m_cfg[b][addr[6:2]] = wdata[6:0];
    if (we && addr == 8'h80) m_mask[b] = wdata;
    if (we && addr == 8'h88) m_gm[b] = wdata[0];
  endtask

  function automatic logic [31:0] m_read(int b, logic [31:0] v);
    if (addr < 8'h80) return {25'd0, m_cfg[b][addr[6:2]]};
    case (addr)
      8'h80: return m_mask[b];
      8'h84: return m_pend(b, v);
      8'h88: return {31'd0, m_gm[b]};
      8'h90: return 32'(m_isrc[b]);
      8'h94: return 32'(m_fsrc[b]);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      l2o = m_irq[1];
      m_step(1, in2, we2, 1'b0);
      m_step(0, {l2o, in1[30:0]}, we1, 1'b1);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6 model irq l1", {31'd0, irq1}, {31'd0, m_irq[0]});
      chk("R7 model fiq l1", {31'd0, fiq1}, {31'd0, m_fiq[0]});
      chk("R9 model irq l2", {31'd0, irq2}, {31'd0, m_irq[1]});
      chk("R9 model fiq l2", {31'd0, fiq2}, {31'd0, m_fiq[1]});
      chk("R3 model rdata l1", rdata1, m_read(0, {m_irq[1], in1[30:0]}));
      chk("R3 model rdata l2", rdata2, m_read(1, in2));
    end
  end

  task automatic wr(bit b, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (b) we2 = 1'b1; else we1 = 1'b1;
    @(posedge clk); #1;
    we1 = 1'b0; we2 = 1'b0;
  endtask

  task automatic rd(bit b, logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; #1;
    chk(tag, b ? rdata2 : rdata1, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(0, 8'h80, 32'hFFFFFFFF, "R1 mask");
    rd(0, 8'h1C, 32'h0, "R1 cfg7");
    rd(0, 8'h84, 32'h0, "R1 status");
    rd(0, 8'h88, 32'h1, "R1 gmask");
    rd(1, 8'h80, 32'hFFFFFFFF, "R1 mask l2");
    chk("R1 outputs", {30'd0, irq1, fiq1}, 32'h0);
    // R8
    wr(0, 8'h0C, 32'h2);
    wr(0, 8'h80, ~32'h8);
    @(negedge clk) in1[3] = 1'b1;
    idle(3);
    chk("R8 blocked", {31'd0, irq1}, 32'h0);
    wr(0, 8'h88, 32'h0);
    idle(2);
    chk("R8 enabled", {31'd0, irq1}, 32'h1);
    rd(0, 8'h90, 32'd3, "R6 src");
    // R6 and R5 tie
    wr(0, 8'h04, 32'h2);
    wr(0, 8'h80, ~32'h0A);
    @(negedge clk) in1[1] = 1'b1;
    idle(2);
    rd(0, 8'h90, 32'd3, "R6 frozen");
    wr(0, 8'h8C, 32'h1);
    chk("R6 ack drop", {31'd0, irq1}, 32'h0);
    @(posedge clk); #1;
    chk("R6 rearb", {31'd0, irq1}, 32'h1);
    rd(0, 8'h90, 32'd1, "R5 tie");
    // R5 priority
    wr(0, 8'h04, 32'h16);
    wr(0, 8'h8C, 32'h1);
    idle(2);
    rd(0, 8'h90, 32'd3, "R5 prio");
    @(negedge clk) begin in1[1] = 1'b0; in1[3] = 1'b0; end
    wr(0, 8'h8C, 32'h1);
    idle(2);
    chk("R6 idle", {31'd0, irq1}, 32'h0);
    // R4 edge
    wr(0, 8'h28, 32'h8);
    wr(0, 8'h80, ~32'h40A);
    @(negedge clk) in1[10] = 1'b1;
    @(negedge clk) in1[10] = 1'b0;
    idle(2);
    rd(0, 8'h84, 32'h400, "R4 latched");
    chk("R4 irq", {31'd0, irq1}, 32'h1);
    rd(0, 8'h90, 32'd10, "R4 src");
    wr(0, 8'h8C, 32'h1);
    idle(2);
    rd(0, 8'h84, 32'h0, "R4 cleared");
    chk("R4 idle", {31'd0, irq1}, 32'h0);
    // R10
    wr(0, 8'h88, 32'h1);
    @(negedge clk) begin in1[10] = 1'b1; in1[12] = 1'b1; end
    @(negedge clk) begin in1[10] = 1'b0; in1[12] = 1'b0; end
    idle(2);
    rd(0, 8'h84, 32'h1400, "R10 both");
    wr(0, 8'h84, ~32'h400);
    rd(0, 8'h84, 32'h1000, "R10 and");
    wr(0, 8'h84, 32'h0);
    rd(0, 8'h84, 32'h0, "R10 zero");
    chk("R8 blocked again", {31'd0, irq1}, 32'h0);
    wr(0, 8'h88, 32'h0);
    // R2
    wr(0, 8'h50, 32'h2);
    @(negedge clk) in1[20] = 1'b1;
    idle(3);
    chk("R2 masked", {31'd0, irq1}, 32'h0);
    rd(0, 8'h84, 32'h100000, "R2 status");
    rd(0, 8'h80, ~32'h40A, "R2 readback");
    @(negedge clk) in1[20] = 1'b0;
    // R3
    wr(0, 8'h7C, 32'hFFFFFFFF);
    rd(0, 8'h7C, 32'h7F, "R3 fields");
    // R7
    wr(0, 8'h14, 32'h7);
    wr(0, 8'h18, 32'h2);
    wr(0, 8'h80, ~32'h46A);
    @(negedge clk) begin in1[5] = 1'b1; in1[6] = 1'b1; end
    idle(2);
    chk("R7 both up", {30'd0, irq1, fiq1}, 32'h3);
    rd(0, 8'h94, 32'd5, "R7 fiq src");
    rd(0, 8'h90, 32'd6, "R7 irq src");
    wr(0, 8'h8C, 32'h3);
    chk("R7 both drop", {30'd0, irq1, fiq1}, 32'h0);
    @(posedge clk); #1;
    chk("R7 both rearb", {30'd0, irq1, fiq1}, 32'h3);
    @(negedge clk) begin in1[5] = 1'b0; in1[6] = 1'b0; end
    wr(0, 8'h8C, 32'h3);
    idle(2);
    chk("R7 idle", {30'd0, irq1, fiq1}, 32'h0);
    // R9
    wr(1, 8'h88, 32'h0);
    wr(1, 8'h10, 32'h7);
    wr(1, 8'h80, ~32'h10);
    @(negedge clk) in2[4] = 1'b1;
    idle(2);
    chk("R9 routing", {30'd0, irq2, fiq2}, 32'h2);
    rd(1, 8'h90, 32'd4, "R9 src");
    rd(1, 8'h94, 32'd0, "R9 fiq src");
    rd(1, 8'h10, 32'h7, "R9 cfg readback");
    // R11
    wr(0, 8'h7C, 32'h2);
    wr(0, 8'h80, ~32'h8000046A);
    idle(2);
    chk("R11 l1 up", {31'd0, irq1}, 32'h1);
    rd(0, 8'h90, 32'd31, "R11 src");
    @(negedge clk) in2[4] = 1'b0;
    wr(0, 8'h8C, 32'h1);
    idle(2);
    chk("R11 l1 again", {31'd0, irq1}, 32'h1);
    wr(1, 8'h8C, 32'h1);
    wr(0, 8'h8C, 32'h1);
    idle(2);
    chk("R11 l1 clear", {31'd0, irq1}, 32'h0);
    chk("R11 l2 clear", {31'd0, irq2}, 32'h0);
    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule